// File: doc/BRIEF.md
# Two-Phase Microword Reassembler

This block rebuilds wide microinstructions that arrive over a control bus half as wide as the word. Each microword comes as two halves, upper half first. A strobe marks when each half is valid. The upper half waits in a staging register. When the lower half arrives, the two halves are joined into a completed word.

The completed word moves into the execution register only on a machine-cycle advance. The execution register therefore changes once per machine cycle, and it never shows one half of a word mixed with a half of another word. A lower-half strobe with no upper half staged before it is a sequencing error. The bad half is dropped and reported on a one-cycle error flag.

All strobes are synchronous enables sampled on the rising edge of `clk`. Each output changes on the rising edge that follows the cycle in which its cause was sampled.

Top module: `mw_reassembler`

## Requirements
- R1: After reset, `exec_word` is all zeros and both `exec_vld` and `seq_err` are 0.
- R2: A cycle with `hi_stb`=1 captures `ctl_bus` as the upper half. Bus bit 19 becomes word bit 39 and bus bit 0 becomes word bit 20. A high bus level is a one.
- R3: A cycle with `lo_stb`=1, with an upper half staged and `hi_stb`=0, completes the word. The staged half fills bits 39..20 and the current `ctl_bus` fills bits 19..0.
- R4: `exec_word` changes only after a cycle with `cyc_adv`=1. Staging or completing halves without an advance leaves it unchanged.
- R5: A cycle with `cyc_adv`=1 while a completed word is waiting loads that word into `exec_word`, sets `exec_vld` to 1 and consumes the word.
- R6: A cycle with `cyc_adv`=1 and no completed word waiting keeps `exec_word` and clears `exec_vld` to 0.
- R7: Some lower strobes are sequencing errors: `lo_stb`=1 with no upper half staged, or `lo_stb`=1 together with `hi_stb`=1. Such a strobe raises `seq_err` for exactly the next cycle. Its bus value is discarded, and any waiting completed word and `exec_word` are kept. In the combined case the upper half is still captured.
- R8: When an accepted lower strobe and `cyc_adv` fall in the same cycle, the advance takes the word completed earlier, or reports no word (R6). The newly completed word waits for the next advance.
- R9: A second upper strobe before the lower strobe replaces the staged upper half. An accepted lower strobe empties the staging, so a further lower strobe is an error (R7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_bus | input | 20 | Multiplexed microword half, bit 19 most significant |
| hi_stb | input | 1 | Upper-half capture strobe |
| lo_stb | input | 1 | Lower-half capture strobe |
| cyc_adv | input | 1 | Machine-cycle advance |
| exec_word | output | 40 | Execution register contents |
| exec_vld | output | 1 | Execution register freshly loaded on the last advance |
| seq_err | output | 1 | One-cycle sequencing error pulse |

## Verification
Two functions can fall in the same cycle: accepting a lower half and a machine-cycle advance. The bench provokes this twice. In the first case a completed word is already waiting. In the second case the waiting slot is empty. It judges the result by whether the advance takes the older word or reports no word, and by whether the new word appears only on the advance after that. A lower strobe in the same cycle as an upper strobe is also driven. The bench checks that the upper half is still captured while the lower half is rejected.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int HALF_W_DFLT = 20;

  // A lower half is accepted only when an upper half is already staged and
  // no new upper half arrives in the same cycle.
  function automatic logic lo_accept(input logic lo, input logic hi, input logic pend);
    return lo && pend && !hi;
  endfunction

  function automatic logic lo_reject(input logic lo, input logic hi, input logic pend);
    return lo && !(pend && !hi);
  endfunction
endpackage

// File: rtl/mw_upper_stage.sv
module mw_upper_stage #(
  parameter int HALF_W = mw_pkg::HALF_W_DFLT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] bus_i,
  input  logic              hi_stb_i,
  input  logic              lo_acc_i,
  output logic [HALF_W-1:0] up_q_o,
  output logic              up_pend_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q_o    <= '0;
      up_pend_o <= 1'b0;
    end else begin
      if (hi_stb_i) begin
        up_q_o    <= bus_i;
        up_pend_o <= 1'b1;
      end else if (lo_acc_i) begin
        up_pend_o <= 1'b0;
      end
    end
  end

  // R2
  hi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_stb_i |=> (up_pend_o && up_q_o == $past(bus_i)));
endmodule

// File: rtl/mw_pair_reg.sv
module mw_pair_reg #(
  parameter int HALF_W = mw_pkg::HALF_W_DFLT,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] bus_i,
  input  logic [HALF_W-1:0] up_q_i,
  input  logic              lo_acc_i,
  input  logic              take_i,
  output logic [WORD_W-1:0] pair_word_o,
  output logic              pair_rdy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_word_o <= '0;
      pair_rdy_o  <= 1'b0;
    end else begin
      if (lo_acc_i) begin
        pair_word_o <= {up_q_i, bus_i};
        pair_rdy_o  <= 1'b1;
      end else if (take_i) begin
        pair_rdy_o  <= 1'b0;
      end
    end
  end

  // R3
  pair_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_acc_i |=> (pair_rdy_o && pair_word_o[HALF_W-1:0] == $past(bus_i)
                  && pair_word_o[WORD_W-1:HALF_W] == $past(up_q_i)));
endmodule

// File: rtl/mw_exec_reg.sv
module mw_exec_reg #(
  parameter int HALF_W = mw_pkg::HALF_W_DFLT,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pair_word_i,
  input  logic              pair_rdy_i,
  input  logic              adv_i,
  output logic [WORD_W-1:0] exec_word_o,
  output logic              exec_vld_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_word_o <= '0;
      exec_vld_o  <= 1'b0;
    end else if (adv_i) begin
      exec_vld_o <= pair_rdy_i;
      if (pair_rdy_i) exec_word_o <= pair_word_i;
    end
  end

  // R4
  exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(exec_word_o) && $stable(exec_vld_o));
  // R6
  empty_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !pair_rdy_i) |=> (!exec_vld_o && $stable(exec_word_o)));
endmodule

// File: rtl/mw_reassembler.sv
module mw_reassembler #(
  parameter int HALF_W = mw_pkg::HALF_W_DFLT,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] ctl_bus,
  input  logic              hi_stb,
  input  logic              lo_stb,
  input  logic              cyc_adv,
  output logic [WORD_W-1:0] exec_word,
  output logic              exec_vld,
  output logic              seq_err
);
  logic [HALF_W-1:0] up_q;
  logic              up_pend;
  logic              lo_acc;
  logic              lo_bad;
  logic [WORD_W-1:0] pair_word;
  logic              pair_rdy;

  assign lo_acc = mw_pkg::lo_accept(lo_stb, hi_stb, up_pend);
  assign lo_bad = mw_pkg::lo_reject(lo_stb, hi_stb, up_pend);

  mw_upper_stage #(.HALF_W(HALF_W)) u_up (
    .clk(clk), .rst_n(rst_n), .bus_i(ctl_bus), .hi_stb_i(hi_stb),
    .lo_acc_i(lo_acc), .up_q_o(up_q), .up_pend_o(up_pend)
  );

  mw_pair_reg #(.HALF_W(HALF_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .bus_i(ctl_bus), .up_q_i(up_q),
    .lo_acc_i(lo_acc), .take_i(cyc_adv),
    .pair_word_o(pair_word), .pair_rdy_o(pair_rdy)
  );

  mw_exec_reg #(.HALF_W(HALF_W)) u_exec (
    .clk(clk), .rst_n(rst_n), .pair_word_i(pair_word), .pair_rdy_i(pair_rdy),
    .adv_i(cyc_adv), .exec_word_o(exec_word), .exec_vld_o(exec_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_err <= 1'b0;
    else        seq_err <= lo_bad;
  end

  // R5
  adv_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_adv && pair_rdy) |=> (exec_vld && exec_word == $past(pair_word)));
  // R7
  seq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_stb && !up_pend) |=> (seq_err && $stable(pair_word)));
  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_acc && !hi_stb) |=> !up_pend);
  // R8
  overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_acc && cyc_adv) |=> pair_rdy);
endmodule

// File: tb/tb_mw_reassembler.sv
module tb_mw_reassembler;
  localparam int HW = 20;
  localparam int WW = 2 * HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [HW-1:0] ctl_bus = '0;
  logic          hi_stb = 1'b0, lo_stb = 1'b0, cyc_adv = 1'b0;
  logic [WW-1:0] exec_word;
  logic          exec_vld, seq_err;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [HW-1:0] m_up = '0;
  logic          m_pend = 1'b0;
  logic [WW-1:0] m_pair = '0;
  logic          m_rdy = 1'b0;
  logic [WW-1:0] m_exec = '0;
  logic          m_vld = 1'b0;
  logic          m_err = 1'b0;

  mw_reassembler #(.HALF_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_bus(ctl_bus), .hi_stb(hi_stb),
    .lo_stb(lo_stb), .cyc_adv(cyc_adv), .exec_word(exec_word),
    .exec_vld(exec_vld), .seq_err(seq_err)
  );

  always #5 clk = ~clk;

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check_outs(input string req);
    checks++;
    if (exec_word !== m_exec || exec_vld !== m_vld || seq_err !== m_err) begin
      failures++;
      $display("FAIL %s: actual word=%h vld=%b err=%b expected word=%h vld=%b err=%b",
               req, exec_word, exec_vld, seq_err, m_exec, m_vld, m_err);
    end
  endtask

  // One cycle: drive at negedge, update model, wait for the edge, check at next negedge.
  task automatic step(input logic h, input logic l, input logic a,
                      input logic [HW-1:0] b, input string req);
    logic acc;
    hi_stb = h; lo_stb = l; cyc_adv = a; ctl_bus = b;
    acc = l && m_pend && !h;
    m_err = l && !acc;
    if (a) begin
      m_vld = m_rdy;
      if (m_rdy) m_exec = m_pair;
    end
    if (acc) begin
      m_pair = {m_up, b};
      m_rdy = 1'b1;
    end else if (a) begin
      m_rdy = 1'b0;
    end
    if (h) begin
      m_up = b;
      m_pend = 1'b1;
    end else if (acc) begin
      m_pend = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    hi_stb = 1'b0; lo_stb = 1'b0; cyc_adv = 1'b0;
    check_outs(req);
  endtask

  task automatic t_reset();
    check_outs("R1");
  endtask

  task automatic t_basic();
    step(1, 0, 0, 20'hA5C3F, "R2");
    step(0, 1, 0, 20'h1234E, "R3");
    step(0, 0, 1, 20'h00000, "R5");
    checks++;
    if (exec_word !== 40'hA5C3F1234E) begin
      failures++;
      $display("FAIL R2: actual %h expected %h", exec_word, 40'hA5C3F1234E);
    end
    step(0, 0, 1, 20'h00000, "R6");
  endtask

  task automatic t_bit_order();
    step(1, 0, 0, 20'h80000, "R2");
    step(0, 1, 0, 20'h00001, "R3");
    step(0, 0, 0, 20'hFFFFF, "R4");
    step(0, 0, 1, 20'h00000, "R5");
    checks++;
    if (exec_word[39] !== 1'b1 || exec_word[0] !== 1'b1 || exec_word[38:1] !== '0) begin
      failures++;
      $display("FAIL R2: actual %h expected %h", exec_word, 40'h8000000001);
    end
  endtask

  task automatic t_seq_err();
    step(0, 1, 0, 20'h77777, "R7");
    step(0, 0, 0, 20'h0, "R7");
    step(0, 0, 1, 20'h0, "R7");
    step(1, 0, 0, 20'h11111, "R2");
    step(0, 1, 0, 20'h22222, "R3");
    step(0, 1, 0, 20'h33333, "R9");
    step(0, 0, 1, 20'h0, "R9");
    step(1, 1, 0, 20'h44444, "R7");
    step(0, 1, 0, 20'h55555, "R7");
    step(0, 0, 1, 20'h0, "R7");
  endtask

  task automatic t_replace_upper();
    step(1, 0, 0, 20'hAAAAA, "R9");
    step(1, 0, 0, 20'hBBBBB, "R9");
    step(0, 1, 0, 20'hCCCCC, "R9");
    step(0, 0, 1, 20'h0, "R9");
  endtask

  task automatic t_overlap();
    step(1, 0, 0, 20'h0F0F0, "R8");
    step(0, 1, 0, 20'h0E0E0, "R8");
    step(1, 0, 0, 20'h0D0D0, "R8");
    step(0, 1, 1, 20'h0C0C0, "R8");
    step(0, 0, 1, 20'h0, "R8");
    step(0, 0, 1, 20'h0, "R6");
    step(1, 0, 0, 20'h12345, "R8");
    step(0, 1, 1, 20'h6789A, "R8");
    step(0, 0, 1, 20'h0, "R8");
  endtask

  task automatic t_no_adv();
    step(1, 0, 0, 20'hFEDCB, "R4");
    step(0, 0, 0, 20'h0, "R4");
    step(0, 1, 0, 20'hA9876, "R4");
    step(0, 0, 0, 20'h0, "R4");
    step(0, 0, 1, 20'h0, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bit_order();
    t_seq_err();
    t_replace_upper();
    t_overlap();
    t_no_adv();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule